// File: doc/BRIEF.md
# Direction-Qualified Position Comparator

This block watches the live encoder position and raises an event when that position reaches a programmed target. It takes the current phase count, revolution (Z) count, speed count and rotation direction. It holds three target registers of its own, one each for phase, revolution and speed. The main condition is phase equality. Revolution equality can be added to it or removed. A direction qualifier can require positive rotation, require negative rotation, or be switched off. Speed equality can also be added; with its enable held low, speed plays no part in the match.

The output is a one-cycle pulse, `match_o`, that marks the cycle after the combined condition turns true. The same pulse also drives one bit of a 32-bit event vector for the downstream flag logic. The block keeps no status and has no interrupt logic. Loading any target register re-arms the detector, so a condition that already holds with the new target produces a fresh pulse.

Top module: `poscmp_top`

## Requirements
- R1: After reset, all three target registers read as 0 and the detector treats the condition as already true, so no pulse appears until the condition changes from false to true or a target register is written.
- R2: A pulse requires `phase_cnt_i` to equal the phase target.
- R3: A pulse lasts exactly one cycle, even while the condition continues to hold.
- R4: With `z_cmp_off_i` = 0, a pulse also requires `z_cnt_i` to equal the Z target.
- R5: With `z_cmp_off_i` = 1, the Z count and the Z target have no effect on matching.
- R6: With `dir_chk_off_i` = 0 and `dir_need_i` = 0 (positive), a pulse requires `dir_i` = 0. Here 0 encodes positive rotation.
- R7: With `dir_chk_off_i` = 0 and `dir_need_i` = 1 (negative), a pulse requires `dir_i` = 1. Here 1 encodes negative rotation.
- R8: With `dir_chk_off_i` = 1, rotation direction has no effect on matching.
- R9: With `spd_chk_on_i` = 1, a pulse also requires `spd_cnt_i` to equal the speed target. With it at 0, the speed count is ignored.
- R10: A write strobe loads its target on that clock edge and re-arms detection. If the condition holds with the new target on the following edge, `match_o` pulses after that edge even though the condition was already true.
- R11: Bit 29 of `event_o` always equals `match_o`, and every other bit of `event_o` is 0.
- R12: `match_o` is registered. It is high in the cycle right after the first cycle in which the inputs satisfy the condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| phase_cnt_i | input | PH_W | Live phase count |
| z_cnt_i | input | Z_W | Live revolution count |
| spd_cnt_i | input | SP_W | Live speed count |
| dir_i | input | 1 | Rotation direction, 0 positive, 1 negative |
| phase_val_i | input | PH_W | Value for the phase target |
| z_val_i | input | Z_W | Value for the Z target |
| spd_val_i | input | SP_W | Value for the speed target |
| wr_phase_i | input | 1 | Load phase target |
| wr_z_i | input | 1 | Load Z target |
| wr_spd_i | input | 1 | Load speed target |
| z_cmp_off_i | input | 1 | Drop Z equality from the condition |
| dir_need_i | input | 1 | Required direction, 0 positive, 1 negative |
| dir_chk_off_i | input | 1 | Ignore direction |
| spd_chk_on_i | input | 1 | Add speed equality to the condition |
| match_o | output | 1 | One-cycle match pulse |
| event_o | output | EVT_W | Event vector, match on bit 29 |

## Verification
The assertions run on every cycle. They check the following:
- Each pulse is preceded by a cycle in which the phase term held.
- In that same cycle, every enabled qualifier held: Z, direction and speed.
- A pulse is never repeated unless a write intervened.
- The event vector carries the pulse on its one bit only.

The assertions cannot show that a pulse actually appears when it should. The bench scenarios cover that:
- the pulse timing after a fresh equality;
- the quiet period after reset;
- the re-arm pulse after rewriting a target that already matches;
- the transitions caused by changing a disable or enable bit while the counts stay fixed.

// File: rtl/poscmp_pkg.sv
package poscmp_pkg;
  typedef enum logic {
    DIR_POS = 1'b0,
    DIR_NEG = 1'b1
  } rot_dir_e;

  localparam int unsigned EVT_W   = 32;
  localparam int unsigned EVT_BIT = 29;
endpackage

// File: rtl/poscmp_regs.sv
module poscmp_regs #(
  parameter int unsigned PH_W = 16,
  parameter int unsigned Z_W  = 16,
  parameter int unsigned SP_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_phase_i,
  input  logic            wr_z_i,
  input  logic            wr_spd_i,
  input  logic [PH_W-1:0] phase_val_i,
  input  logic [Z_W-1:0]  z_val_i,
  input  logic [SP_W-1:0] spd_val_i,
  output logic [PH_W-1:0] phase_q_o,
  output logic [Z_W-1:0]  z_q_o,
  output logic [SP_W-1:0] spd_q_o,
  output logic            rearm_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q_o <= '0;
      z_q_o     <= '0;
      spd_q_o   <= '0;
      rearm_o   <= 1'b0;
    end else begin
      if (wr_phase_i) phase_q_o <= phase_val_i;
      if (wr_z_i)     z_q_o     <= z_val_i;
      if (wr_spd_i)   spd_q_o   <= spd_val_i;
      rearm_o <= wr_phase_i | wr_z_i | wr_spd_i;
    end
  end

  // R10: a strobe is always followed by a re-arm cycle
  a_r10_rearm_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_phase_i || wr_z_i || wr_spd_i) |=> rearm_o);

  a_r10_phase_loaded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_phase_i |=> (phase_q_o == $past(phase_val_i)));
endmodule

// File: rtl/poscmp_cond.sv
module poscmp_cond #(
  parameter int unsigned PH_W = 16,
  parameter int unsigned Z_W  = 16,
  parameter int unsigned SP_W = 16
) (
  input  logic            [PH_W-1:0] phase_cnt_i,
  input  logic            [PH_W-1:0] phase_ref_i,
  input  logic            [Z_W-1:0]  z_cnt_i,
  input  logic            [Z_W-1:0]  z_ref_i,
  input  logic            [SP_W-1:0] spd_cnt_i,
  input  logic            [SP_W-1:0] spd_ref_i,
  input  poscmp_pkg::rot_dir_e       dir_i,
  input  poscmp_pkg::rot_dir_e       dir_need_i,
  input  logic                       z_cmp_off_i,
  input  logic                       dir_chk_off_i,
  input  logic                       spd_chk_on_i,
  output logic                       hit_o
);
  logic phase_ok, z_ok, dir_ok, spd_ok;

  always_comb begin
    phase_ok = (phase_cnt_i == phase_ref_i);
    z_ok     = z_cmp_off_i   || (z_cnt_i == z_ref_i);
    dir_ok   = dir_chk_off_i || (dir_i == dir_need_i);
    spd_ok   = !spd_chk_on_i || (spd_cnt_i == spd_ref_i);
    hit_o    = phase_ok && z_ok && dir_ok && spd_ok;
  end
endmodule

// File: rtl/poscmp_edge.sv
module poscmp_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic rearm_i,
  output logic match_o
);
  logic hit_q;

  // hit_q resets high so a condition true out of reset does not fire
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_q   <= 1'b1;
      match_o <= 1'b0;
    end else begin
      hit_q   <= hit_i;
      match_o <= hit_i && (!hit_q || rearm_i);
    end
  end

  a_r3_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_o && !rearm_i) |=> !match_o);

  a_r12_pulse_follows_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> $past(hit_i));
endmodule

// File: rtl/poscmp_top.sv
module poscmp_top import poscmp_pkg::*; #(
  parameter int unsigned PH_W = 16,
  parameter int unsigned Z_W  = 16,
  parameter int unsigned SP_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PH_W-1:0]  phase_cnt_i,
  input  logic [Z_W-1:0]   z_cnt_i,
  input  logic [SP_W-1:0]  spd_cnt_i,
  input  logic             dir_i,
  input  logic [PH_W-1:0]  phase_val_i,
  input  logic [Z_W-1:0]   z_val_i,
  input  logic [SP_W-1:0]  spd_val_i,
  input  logic             wr_phase_i,
  input  logic             wr_z_i,
  input  logic             wr_spd_i,
  input  logic             z_cmp_off_i,
  input  logic             dir_need_i,
  input  logic             dir_chk_off_i,
  input  logic             spd_chk_on_i,
  output logic             match_o,
  output logic [EVT_W-1:0] event_o
);
  logic [PH_W-1:0] phase_q;
  logic [Z_W-1:0]  z_q;
  logic [SP_W-1:0] spd_q;
  logic            rearm, hit;

  poscmp_regs #(.PH_W(PH_W), .Z_W(Z_W), .SP_W(SP_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_phase_i  (wr_phase_i),
    .wr_z_i      (wr_z_i),
    .wr_spd_i    (wr_spd_i),
    .phase_val_i (phase_val_i),
    .z_val_i     (z_val_i),
    .spd_val_i   (spd_val_i),
    .phase_q_o   (phase_q),
    .z_q_o       (z_q),
    .spd_q_o     (spd_q),
    .rearm_o     (rearm)
  );

  poscmp_cond #(.PH_W(PH_W), .Z_W(Z_W), .SP_W(SP_W)) u_cond (
    .phase_cnt_i   (phase_cnt_i),
    .phase_ref_i   (phase_q),
    .z_cnt_i       (z_cnt_i),
    .z_ref_i       (z_q),
    .spd_cnt_i     (spd_cnt_i),
    .spd_ref_i     (spd_q),
    .dir_i         (rot_dir_e'(dir_i)),
    .dir_need_i    (rot_dir_e'(dir_need_i)),
    .z_cmp_off_i   (z_cmp_off_i),
    .dir_chk_off_i (dir_chk_off_i),
    .spd_chk_on_i  (spd_chk_on_i),
    .hit_o         (hit)
  );

  poscmp_edge u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hit_i   (hit),
    .rearm_i (rearm),
    .match_o (match_o)
  );

  for (genvar b = 0; b < EVT_W; b++) begin : g_evt
    if (b == EVT_BIT) begin : g_hit
      assign event_o[b] = match_o;
    end else begin : g_zero
      assign event_o[b] = 1'b0;
    end
  end

  a_r2_phase_equal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> $past(phase_cnt_i == phase_q));

  a_r4_z_equal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> $past(z_cmp_off_i || (z_cnt_i == z_q)));

  // R6, R7, R8
  a_r6_dir_qual: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> $past(dir_chk_off_i || (dir_i == dir_need_i)));

  a_r9_spd_equal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> $past(!spd_chk_on_i || (spd_cnt_i == spd_q)));

  a_r11_event_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(event_o));
endmodule

// File: tb/poscmp_top_tb.sv
module poscmp_top_tb;
  import poscmp_pkg::*;

  localparam int unsigned W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] ph = '0, zc = '0, sc = '0, ph_v = '0, z_v = '0, s_v = '0;
  logic dir = 1'b0, wph = 1'b0, wz = 1'b0, ws = 1'b0;
  logic z_off = 1'b0, need = 1'b0, d_off = 1'b0, s_on = 1'b0;
  logic match;
  logic [EVT_W-1:0] evt;

  int total = 0;
  int bad = 0;
  bit exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  poscmp_top #(.PH_W(W), .Z_W(W), .SP_W(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .phase_cnt_i(ph), .z_cnt_i(zc), .spd_cnt_i(sc), .dir_i(dir),
    .phase_val_i(ph_v), .z_val_i(z_v), .spd_val_i(s_v),
    .wr_phase_i(wph), .wr_z_i(wz), .wr_spd_i(ws),
    .z_cmp_off_i(z_off), .dir_need_i(need), .dir_chk_off_i(d_off),
    .spd_chk_on_i(s_on), .match_o(match), .event_o(evt)
  );

  // driver: queue the value expected after the coming rising edge
  task automatic tick(input bit e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (exp_q.size() > 0) begin
        bit e;
        string t;
        logic [EVT_W-1:0] ev;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        ev = '0;
        ev[EVT_BIT] = e;
        total++;
        if (match !== e) begin
          bad++;
          $display("FAIL %s match_o=%0b expected %0b", t, match, e);
        end
        total++;
        if (evt !== ev) begin
          bad++;
          $display("FAIL R11 (%s) event_o=%h expected %h", t, evt, ev);
        end
      end
    end
  end

  initial begin
    #2000000;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: counts 0 equal reset targets 0, no pulse
    tick(1'b0, "R1");
    tick(1'b0, "R1");
    tick(1'b0, "R1");

    // R2 / R12 / R3: phase only
    z_off = 1'b1; d_off = 1'b1;
    ph_v = 16'd100; wph = 1'b1;
    tick(1'b0, "R1");
    wph = 1'b0;
    tick(1'b0, "R2");
    ph = 16'd99;  tick(1'b0, "R2");
    ph = 16'd100; tick(1'b1, "R12");
    tick(1'b0, "R3");
    tick(1'b0, "R3");
    ph = 16'd101; tick(1'b0, "R2");
    ph = 16'd100; tick(1'b1, "R2");

    // R4: Z included
    z_off = 1'b0; z_v = 16'd5; wz = 1'b1;
    tick(1'b0, "R4");
    wz = 1'b0;
    tick(1'b0, "R4");
    zc = 16'd5; tick(1'b1, "R4");
    zc = 16'd6; tick(1'b0, "R4");
    // R5: Z excluded
    z_off = 1'b1; tick(1'b1, "R5");
    tick(1'b0, "R5");
    zc = 16'd7; tick(1'b0, "R5");
    ph = 16'd99;  tick(1'b0, "R5");
    ph = 16'd100; tick(1'b1, "R5");

    // R6: positive rotation required
    d_off = 1'b0; need = DIR_POS; ph = 16'd99;
    tick(1'b0, "R6");
    dir = DIR_NEG; ph = 16'd100; tick(1'b0, "R6");
    dir = DIR_POS; tick(1'b1, "R6");
    dir = DIR_NEG; tick(1'b0, "R6");
    // R7: negative rotation required
    need = DIR_NEG; tick(1'b1, "R7");
    dir = DIR_POS; tick(1'b0, "R7");
    dir = DIR_NEG; tick(1'b1, "R7");
    // R8: direction ignored
    d_off = 1'b1; dir = DIR_POS; tick(1'b0, "R8");
    ph = 16'd99;  tick(1'b0, "R8");
    ph = 16'd100; tick(1'b1, "R8");
    dir = DIR_NEG; tick(1'b0, "R8");

    // R9: speed
    s_on = 1'b1; s_v = 16'd40; ws = 1'b1;
    tick(1'b0, "R9");
    ws = 1'b0;
    tick(1'b0, "R9");
    sc = 16'd40; tick(1'b1, "R9");
    sc = 16'd41; tick(1'b0, "R9");
    s_on = 1'b0; tick(1'b1, "R9");
    sc = 16'd7;  tick(1'b0, "R9");

    // R10: re-arm on write while condition holds
    ph_v = 16'd100; wph = 1'b1;
    tick(1'b0, "R10");
    wph = 1'b0;
    tick(1'b1, "R10");
    tick(1'b0, "R10");
    z_v = 16'd9; wz = 1'b1;
    tick(1'b0, "R10");
    wz = 1'b0;
    tick(1'b1, "R10");
    // write while false: no pulse until equality arrives
    ph = 16'd50; ph_v = 16'd77; wph = 1'b1;
    tick(1'b0, "R10");
    wph = 1'b0;
    tick(1'b0, "R10");
    ph = 16'd77; tick(1'b1, "R10");
    tick(1'b0, "R3");

    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule